// File: doc/BRIEF.md
# Store Queue with Load Forwarding

This block keeps every in-flight store of a core in program order, from the moment it is allocated until it is written to memory. Allocation hands out an age tag: the queue's tail pointer together with its wrap bit. The address and the data of a store arrive later, through two separate write ports, in either order. Each port is addressed by that tag.

A load presents its address, its size and an age tag. The age tag is the value the allocation tag had when the load was dispatched, so every store with an earlier tag is older than the load. In the same cycle, the queue answers in one of three ways:
- it forwards the bytes from the youngest older store that covers the load;
- it reports a miss, meaning the cache may be read;
- it tells the load to stall.

A store leaves the queue in two steps. The core first retires it, in order. The queue then sends it from the head to a memory-write port, one store per cycle. On a squash, a flush discards all stores that have not yet been retired, starting at a given age.

Top module: `store_fwd_queue`

## Requirements
- R1: After reset the queue is empty, `alloc_tag` is 0, `alloc_ready` is 1 and `mem_wr_valid` is 0. Each accepted allocation increments the 5-bit tag, which wraps modulo 32. `alloc_ready` is 0 while 16 stores are held or while `flush_valid` is high, and an allocation request in that state is ignored.
- R2: Address and data writes select their store by full tag, wrap bit included, and may arrive in either order. A write whose tag is not currently held is ignored. The size code is 0, 1, 2 or 3 for 1, 2, 4 or 8 bytes.
- R3: `ld_result` is 0 for a miss, 1 for a forward and 2 for a stall. A miss is returned when every older store has a known address and none of them overlaps the load. `ld_data` is 0 unless the result is a forward.
- R4: If any older store still lacks an address, the result is a stall.
- R5: When the youngest older store that overlaps the load contains all of the load's bytes and its data is present, the result is a forward. The bytes are taken little-endian from the store's data, shifted by the address difference, and every bit above the load's size is zero.
- R6: When the youngest older overlapping store covers only part of the load, the result is a stall. This includes loads whose bytes would come from several stores.
- R7: When the covering store's data has not been written yet, the result is a stall.
- R8: A load that spans a 64-byte line boundary stalls if it overlaps any older store, and is a miss if it overlaps none.
- R9: Each `retire_valid` pulse marks the oldest unretired store as retired; the pulse is ignored if no unretired store exists. The head store, once retired, is offered on the write port and held steady until `mem_wr_ready`. A store that has drained no longer takes part in lookups.
- R10: A flush applies only if `flush_tag` names a store that is still unretired after this cycle's retirement. The tail then moves to `flush_tag`. Any other flush is ignored, and retired stores are never dropped.
- R11: Stores whose tags are equal to or younger than the load's tag are not visible to that load's lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Request to allocate one store |
| alloc_ready | output | 1 | An allocation is accepted this cycle |
| alloc_tag | output | 5 | Tag given to the next store (tail pointer with wrap bit) |
| addr_valid | input | 1 | Write an address into a store |
| addr_tag | input | 5 | Target store of the address write |
| addr_addr | input | 32 | Byte address of the store |
| addr_size | input | 2 | Size code of the store |
| data_valid | input | 1 | Write data into a store |
| data_tag | input | 5 | Target store of the data write |
| data_value | input | 64 | Store data, lowest byte at the store address |
| retire_valid | input | 1 | Retire the oldest unretired store |
| flush_valid | input | 1 | Discard younger stores |
| flush_tag | input | 5 | Oldest store to discard |
| ld_valid | input | 1 | A load lookup is present |
| ld_tag | input | 5 | Allocation tag value when the load was dispatched |
| ld_addr | input | 32 | Byte address of the load |
| ld_size | input | 2 | Size code of the load |
| ld_result | output | 2 | 0 miss, 1 forward, 2 stall |
| ld_data | output | 64 | Forwarded bytes, right-aligned |
| mem_wr_valid | output | 1 | Retired head store is offered |
| mem_wr_ready | input | 1 | Memory accepts the offered store |
| mem_wr_addr | output | 32 | Address of the offered store |
| mem_wr_size | output | 2 | Size code of the offered store |
| mem_wr_data | output | 64 | Data of the offered store |

## Verification
Retirement and flush can land in the same cycle. The bench raises `retire_valid` together with a `flush_tag` that names the store just behind the one being retired. It then checks two things: the allocation tag drops back to that store, and the retired store stays on the write port. A second flush, aimed at that retired store, must leave both the tag and the write port unchanged. Draining and allocation also meet: with the queue full, one drain must reopen `alloc_ready` in the next cycle, and the next allocation must then carry the wrapped tag.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
  localparam int MAXB = 8;

  typedef enum logic [1:0] {
    LD_MISS  = 2'd0,
    LD_FWD   = 2'd1,
    LD_STALL = 2'd2
  } ld_res_e;

  function automatic logic [3:0] nbytes(logic [1:0] sz);
    return 4'd1 << sz;
  endfunction

  // true when a load starting at offset 'off' inside a line runs past its end
  function automatic logic crosses_line(int unsigned off, logic [1:0] sz, int unsigned line);
    return (off + int'(nbytes(sz))) > line;
  endfunction

  // shift store bytes down by 'sh' and keep only the load's width
  function automatic logic [63:0] take_bytes(logic [63:0] d, logic [2:0] sh, logic [1:0] sz);
    logic [63:0] s;
    logic [63:0] m;
    s = d >> {sh, 3'b000};
    case (sz)
      2'd0:    m = 64'h0000_0000_0000_00FF;
      2'd1:    m = 64'h0000_0000_0000_FFFF;
      2'd2:    m = 64'h0000_0000_FFFF_FFFF;
      default: m = '1;
    endcase
    return s & m;
  endfunction
endpackage

// File: rtl/sfq_entry_cmp.sv
module sfq_entry_cmp #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] st_addr,
  input  logic [1:0]    st_sz,
  input  logic [AW-1:0] ld_addr,
  input  logic [1:0]    ld_sz,
  output logic          overlap,
  output logic          covers,
  output logic [2:0]    shift
);
  import sfq_pkg::*;

  logic [AW:0] s_lo, s_hi, l_lo, l_hi;

  assign s_lo = {1'b0, st_addr};
  assign s_hi = s_lo + (AW+1)'(nbytes(st_sz));
  assign l_lo = {1'b0, ld_addr};
  assign l_hi = l_lo + (AW+1)'(nbytes(ld_sz));

  assign overlap = (s_lo < l_hi) && (l_lo < s_hi);
  assign covers  = (s_lo <= l_lo) && (l_hi <= s_hi);
  assign shift   = ld_addr[2:0] - st_addr[2:0];
endmodule

// File: rtl/sfq_pick.sv
module sfq_pick #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] cand,
  input  logic [DEPTH-1:0] unres,
  input  logic [IW-1:0]    head_idx,
  output logic             any_hit,
  output logic             any_unres,
  output logic [IW-1:0]    sel_idx
);
  // walk from oldest to youngest; the last hit wins, i.e. the youngest
  always_comb begin
    logic [IW-1:0] idx;
    any_hit   = 1'b0;
    any_unres = |unres;
    sel_idx   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_idx + IW'(k);
      if (cand[idx]) begin
        any_hit = 1'b1;
        sel_idx = idx;
      end
    end
  end
endmodule

// File: rtl/store_fwd_queue.sv
module store_fwd_queue #(
  parameter int DEPTH      = 16,
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_valid,
  output logic                   alloc_ready,
  output logic [$clog2(DEPTH):0] alloc_tag,
  input  logic                   addr_valid,
  input  logic [$clog2(DEPTH):0] addr_tag,
  input  logic [AW-1:0]          addr_addr,
  input  logic [1:0]             addr_size,
  input  logic                   data_valid,
  input  logic [$clog2(DEPTH):0] data_tag,
  input  logic [63:0]            data_value,
  input  logic                   retire_valid,
  input  logic                   flush_valid,
  input  logic [$clog2(DEPTH):0] flush_tag,
  input  logic                   ld_valid,
  input  logic [$clog2(DEPTH):0] ld_tag,
  input  logic [AW-1:0]          ld_addr,
  input  logic [1:0]             ld_size,
  output logic [1:0]             ld_result,
  output logic [63:0]            ld_data,
  output logic                   mem_wr_valid,
  input  logic                   mem_wr_ready,
  output logic [AW-1:0]          mem_wr_addr,
  output logic [1:0]             mem_wr_size,
  output logic [63:0]            mem_wr_data
);
  import sfq_pkg::*;

  localparam int IW = $clog2(DEPTH);
  localparam int PW = IW + 1;
  localparam int LW = $clog2(LINE_BYTES);

  logic [PW-1:0] head_q, tail_q, rptr_q;
  logic [AW-1:0] e_addr [DEPTH];
  logic [1:0]    e_sz   [DEPTH];
  logic [63:0]   e_data [DEPTH];
  logic [DEPTH-1:0] e_av, e_dv, e_ret;

  // named events, also watched by the checker
  logic [PW-1:0] q_count, rptr_nxt, ld_pos;
  logic          alloc_fire, retire_fire, flush_take, drain_fire;
  logic          addr_hit, data_hit;
  logic          unres_seen, hit_seen, cross_seen, head_retired;
  logic [IW-1:0] head_idx, sel_idx;

  function automatic logic held(logic [PW-1:0] tag, logic [PW-1:0] hd, logic [PW-1:0] cnt);
    return (tag - hd) < cnt;
  endfunction

  assign q_count     = tail_q - head_q;
  assign head_idx    = head_q[IW-1:0];
  assign alloc_ready = (q_count != PW'(DEPTH)) && !flush_valid;
  assign alloc_tag   = tail_q;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign retire_fire = retire_valid && (rptr_q != tail_q);
  assign rptr_nxt    = rptr_q + PW'(retire_fire);
  assign flush_take  = flush_valid && ((flush_tag - rptr_nxt) < (tail_q - rptr_nxt));
  assign addr_hit    = addr_valid && held(addr_tag, head_q, q_count);
  assign data_hit    = data_valid && held(data_tag, head_q, q_count);

  assign mem_wr_valid = head_q != rptr_q;
  assign drain_fire   = mem_wr_valid && mem_wr_ready;
  assign mem_wr_addr  = e_addr[head_idx];
  assign mem_wr_size  = e_sz[head_idx];
  assign mem_wr_data  = e_data[head_idx];
  assign head_retired = e_ret[head_idx];

  // pointers and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      rptr_q <= '0;
      e_av   <= '0;
      e_dv   <= '0;
      e_ret  <= '0;
    end else begin
      if (drain_fire) head_q <= head_q + PW'(1);
      rptr_q <= rptr_nxt;
      if (flush_take)      tail_q <= flush_tag;
      else if (alloc_fire) tail_q <= tail_q + PW'(1);
      if (alloc_fire) begin
        e_av[tail_q[IW-1:0]]  <= 1'b0;
        e_dv[tail_q[IW-1:0]]  <= 1'b0;
        e_ret[tail_q[IW-1:0]] <= 1'b0;
      end
      if (addr_hit)    e_av[addr_tag[IW-1:0]] <= 1'b1;
      if (data_hit)    e_dv[data_tag[IW-1:0]] <= 1'b1;
      if (retire_fire) e_ret[rptr_q[IW-1:0]]  <= 1'b1;
    end
  end

  // payload storage
  always_ff @(posedge clk) begin
    if (addr_hit) begin
      e_addr[addr_tag[IW-1:0]] <= addr_addr;
      e_sz[addr_tag[IW-1:0]]   <= addr_size;
    end
    if (data_hit) e_data[data_tag[IW-1:0]] <= data_value;
  end

  // per-entry age and footprint compare
  logic [DEPTH-1:0] older, ovl, cov, cand, unres;
  logic [2:0]       shf [DEPTH];

  assign ld_pos = ld_tag - head_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [IW-1:0] off;
    assign off      = IW'(i) - head_idx;
    assign older[i] = ({1'b0, off} < ld_pos) && ({1'b0, off} < q_count);
    sfq_entry_cmp #(.AW(AW)) u_cmp (
      .st_addr (e_addr[i]),
      .st_sz   (e_sz[i]),
      .ld_addr (ld_addr),
      .ld_sz   (ld_size),
      .overlap (ovl[i]),
      .covers  (cov[i]),
      .shift   (shf[i])
    );
    assign cand[i]  = older[i] & e_av[i] & ovl[i];
    assign unres[i] = older[i] & ~e_av[i];
  end

  sfq_pick #(.DEPTH(DEPTH)) u_pick (
    .cand      (cand),
    .unres     (unres),
    .head_idx  (head_idx),
    .any_hit   (hit_seen),
    .any_unres (unres_seen),
    .sel_idx   (sel_idx)
  );

  assign cross_seen = crosses_line(int'(ld_addr[LW-1:0]), ld_size, LINE_BYTES);

  always_comb begin
    ld_result = LD_MISS;
    ld_data   = '0;
    if (ld_valid) begin
      if (unres_seen)         ld_result = LD_STALL;
      else if (hit_seen) begin
        if (cross_seen)       ld_result = LD_STALL;
        else if (!cov[sel_idx]) ld_result = LD_STALL;
        else if (!e_dv[sel_idx]) ld_result = LD_STALL;
        else begin
          ld_result = LD_FWD;
          ld_data   = take_bytes(e_data[sel_idx], shf[sel_idx], ld_size);
        end
      end
    end
  end
endmodule

// File: rtl/sfq_checker.sv
module sfq_checker #(
  parameter int DEPTH = 16,
  parameter int AW    = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   alloc_ready,
  input logic [$clog2(DEPTH):0] q_count,
  input logic                   ld_valid,
  input logic [1:0]             ld_result,
  input logic                   unres_seen,
  input logic                   hit_seen,
  input logic                   cross_seen,
  input logic                   mem_wr_valid,
  input logic                   mem_wr_ready,
  input logic [AW-1:0]          mem_wr_addr,
  input logic [63:0]            mem_wr_data,
  input logic                   head_retired
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= ($clog2(DEPTH)+1)'(DEPTH)); // R1
  AST_FULL_BLOCKS_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    q_count == ($clog2(DEPTH)+1)'(DEPTH) |-> !alloc_ready); // R1
  AST_UNRESOLVED_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && unres_seen |-> ld_result == 2'd2); // R4
  AST_CROSS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && hit_seen && cross_seen |-> ld_result == 2'd2); // R8
  AST_FWD_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_result == 2'd1 |-> hit_seen && !unres_seen); // R5
  AST_NO_HIT_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !hit_seen && !unres_seen |-> ld_result == 2'd0); // R3
  AST_DRAIN_RETIRED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> head_retired); // R9
  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)); // R9
endmodule

bind store_fwd_queue sfq_checker #(.DEPTH(DEPTH), .AW(AW)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alloc_ready  (alloc_ready),
  .q_count      (q_count),
  .ld_valid     (ld_valid),
  .ld_result    (ld_result),
  .unres_seen   (unres_seen),
  .hit_seen     (hit_seen),
  .cross_seen   (cross_seen),
  .mem_wr_valid (mem_wr_valid),
  .mem_wr_ready (mem_wr_ready),
  .mem_wr_addr  (mem_wr_addr),
  .mem_wr_data  (mem_wr_data),
  .head_retired (head_retired)
);

// File: tb/test_store_fwd_queue.sv
`timescale 1ns/1ps
module test_store_fwd_queue;
  logic        clk, rst_n;
  logic        alloc_valid, alloc_ready;
  logic [4:0]  alloc_tag;
  logic        addr_valid;
  logic [4:0]  addr_tag;
  logic [31:0] addr_addr;
  logic [1:0]  addr_size;
  logic        data_valid;
  logic [4:0]  data_tag;
  logic [63:0] data_value;
  logic        retire_valid, flush_valid;
  logic [4:0]  flush_tag;
  logic        ld_valid;
  logic [4:0]  ld_tag;
  logic [31:0] ld_addr;
  logic [1:0]  ld_size;
  logic [1:0]  ld_result;
  logic [63:0] ld_data;
  logic        mem_wr_valid, mem_wr_ready;
  logic [31:0] mem_wr_addr;
  logic [1:0]  mem_wr_size;
  logic [63:0] mem_wr_data;

  store_fwd_queue i_store_fwd_queue (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  localparam logic [1:0] MISS = 2'd0, FWD = 2'd1, STALL = 2'd2;

  typedef struct packed {
    logic [31:0] a;
    logic [1:0]  sz;
    logic [4:0]  tag;
    logic [1:0]  res;
    logic [63:0] d;
    logic [3:0]  rq;
  } vec_t;

  // stores held: S0 0x100/8B, S1 0x104/4B, S2 0x178/8B, S3 0x200/2B (no data)
  localparam vec_t VECS [13] = '{
    '{32'h100, 2'd3, 5'd4, STALL, 64'h0,         4'd6},  // R6 youngest overlap S1 partial
    '{32'h104, 2'd2, 5'd4, FWD,   64'hDDCCBBAA,  4'd5},  // R5 exact S1
    '{32'h105, 2'd1, 5'd4, FWD,   64'hCCBB,      4'd5},  // R5 shifted inside S1
    '{32'h102, 2'd1, 5'd4, FWD,   64'h4433,      4'd5},  // R5 inside S0 only
    '{32'h100, 2'd2, 5'd1, FWD,   64'h44332211,  4'd11}, // R11 only S0 older
    '{32'h104, 2'd2, 5'd1, FWD,   64'h88776655,  4'd11}, // R11 S1 hidden
    '{32'h17C, 2'd3, 5'd4, STALL, 64'h0,         4'd8},  // R8 crossing with overlap
    '{32'h13E, 2'd2, 5'd4, MISS,  64'h0,         4'd8},  // R8 crossing, no overlap
    '{32'h200, 2'd0, 5'd4, STALL, 64'h0,         4'd7},  // R7 data missing
    '{32'h201, 2'd0, 5'd3, MISS,  64'h0,         4'd11}, // R11 S3 not older
    '{32'h103, 2'd1, 5'd4, STALL, 64'h0,         4'd6},  // R6 spans S0 and S1
    '{32'h180, 2'd2, 5'd4, MISS,  64'h0,         4'd3},  // R3 no overlap
    '{32'h100, 2'd0, 5'd0, MISS,  64'h0,         4'd11}  // R11 nothing older
  };

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
      summary();
      $finish;
    end
  end

  task automatic cyc;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(logic [31:0] a, logic [1:0] sz, logic [4:0] tag, string req,
                      logic [1:0] res, logic [63:0] d);
    ld_valid = 1'b1; ld_addr = a; ld_size = sz; ld_tag = tag;
    #1;
    chk(req, 64'(ld_result), 64'(res));
    chk(req, ld_data, d);
    ld_valid = 1'b0;
  endtask

  task automatic alloc_n(int n);
    alloc_valid = 1'b1;
    repeat (n) cyc();
    alloc_valid = 1'b0;
  endtask

  task automatic wr_addr(logic [4:0] tag, logic [31:0] a, logic [1:0] sz);
    addr_valid = 1'b1; addr_tag = tag; addr_addr = a; addr_size = sz;
    cyc();
    addr_valid = 1'b0;
  endtask

  task automatic wr_data(logic [4:0] tag, logic [63:0] d);
    data_valid = 1'b1; data_tag = tag; data_value = d;
    cyc();
    data_valid = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
  endtask

  initial begin
    alloc_valid = 0; addr_valid = 0; addr_tag = 0; addr_addr = 0; addr_size = 0;
    data_valid = 0; data_tag = 0; data_value = 0; retire_valid = 0;
    flush_valid = 0; flush_tag = 0; ld_valid = 0; ld_tag = 0; ld_addr = 0;
    ld_size = 0; mem_wr_ready = 0;
    do_reset();

    // R1 reset state
    chk("R1", 64'(alloc_ready), 64'd1);
    chk("R1", 64'(alloc_tag), 64'd0);
    chk("R1", 64'(mem_wr_valid), 64'd0);
    look(32'h100, 2'd3, 5'd0, "R3", MISS, 64'h0);

    alloc_n(4);
    chk("R1", 64'(alloc_tag), 64'd4);
    wr_data(5'd0, 64'h8877665544332211);   // R2 data before address
    wr_addr(5'd0, 32'h100, 2'd3);
    wr_addr(5'd1, 32'h104, 2'd2);
    wr_data(5'd1, 64'hDDCCBBAA);
    wr_addr(5'd2, 32'h178, 2'd3);
    wr_data(5'd2, 64'h0F0E0D0C0B0A0908);
    wr_addr(5'd3, 32'h200, 2'd1);

    for (int v = 0; v < 13; v++)
      look(VECS[v].a, VECS[v].sz, VECS[v].tag, $sformatf("R%0d vec%0d", VECS[v].rq, v),
           VECS[v].res, VECS[v].d);

    // R4 unresolved older store
    alloc_n(1);
    look(32'h300, 2'd1, 5'd5, "R4", STALL, 64'h0);
    look(32'h300, 2'd1, 5'd4, "R4", MISS, 64'h0);
    wr_addr(5'd4, 32'h300, 2'd1);
    wr_data(5'd4, 64'h1234);
    look(32'h300, 2'd0, 5'd5, "R2", FWD, 64'h34);

    // R7 data arrives late
    wr_data(5'd3, 64'hBEEF);
    look(32'h200, 2'd0, 5'd4, "R7", FWD, 64'hEF);

    // R2 write with wrong wrap bit is ignored
    wr_addr(5'b10011, 32'h500, 2'd0);
    look(32'h200, 2'd0, 5'd4, "R2", FWD, 64'hEF);

    // R10 flush of S4, R1 ready low during flush
    flush_valid = 1'b1; flush_tag = 5'd4;
    #1 chk("R1", 64'(alloc_ready), 64'd0);
    cyc();
    flush_valid = 1'b0;
    chk("R10", 64'(alloc_tag), 64'd4);

    // R9 retire and drain
    retire_valid = 1'b1; cyc(); retire_valid = 1'b0;
    chk("R9", 64'(mem_wr_valid), 64'd1);
    chk("R9", 64'(mem_wr_addr), 64'h100);
    chk("R9", mem_wr_data, 64'h8877665544332211);
    chk("R9", 64'(mem_wr_size), 64'd3);
    cyc();
    chk("R9", 64'(mem_wr_addr), 64'h100);
    retire_valid = 1'b1; cyc(); retire_valid = 1'b0;
    mem_wr_ready = 1'b1;
    cyc();
    chk("R9", 64'(mem_wr_addr), 64'h104);
    chk("R9", mem_wr_data, 64'hDDCCBBAA);
    cyc();
    mem_wr_ready = 1'b0;
    chk("R9", 64'(mem_wr_valid), 64'd0);
    look(32'h104, 2'd2, 5'd4, "R9", MISS, 64'h0);

    // R10 retire and flush in one cycle
    alloc_n(2);
    retire_valid = 1'b1; flush_valid = 1'b1; flush_tag = 5'd3;
    cyc();
    retire_valid = 1'b0; flush_valid = 1'b0;
    chk("R10", 64'(alloc_tag), 64'd3);
    chk("R10", 64'(mem_wr_valid), 64'd1);
    chk("R10", 64'(mem_wr_addr), 64'h178);
    flush_valid = 1'b1; flush_tag = 5'd2;
    cyc();
    flush_valid = 1'b0;
    chk("R10", 64'(alloc_tag), 64'd3);
    chk("R10", 64'(mem_wr_addr), 64'h178);
    retire_valid = 1'b1; cyc(); retire_valid = 1'b0;   // nothing to retire
    mem_wr_ready = 1'b1; cyc(); mem_wr_ready = 1'b0;
    chk("R9", 64'(mem_wr_valid), 64'd0);

    // R1 full queue and wrap
    do_reset();
    chk("R1", 64'(alloc_tag), 64'd0);
    chk("R1", 64'(mem_wr_valid), 64'd0);
    alloc_n(16);
    chk("R1", 64'(alloc_ready), 64'd0);
    chk("R1", 64'(alloc_tag), 64'd16);
    alloc_n(1);
    chk("R1", 64'(alloc_tag), 64'd16);
    addr_valid = 1'b1; addr_tag = 5'd0; addr_addr = 32'h40; addr_size = 2'd2;
    data_valid = 1'b1; data_tag = 5'd0; data_value = 64'h1111;
    cyc();
    addr_valid = 1'b0; data_valid = 1'b0;
    retire_valid = 1'b1; cyc(); retire_valid = 1'b0;
    chk("R1", 64'(alloc_ready), 64'd0);
    chk("R9", 64'(mem_wr_addr), 64'h40);
    mem_wr_ready = 1'b1; cyc(); mem_wr_ready = 1'b0;
    chk("R1", 64'(alloc_ready), 64'd1);
    alloc_n(1);
    chk("R1", 64'(alloc_tag), 64'd17);

    summary();
    $finish;
  end
endmodule